// File: doc/BRIEF.md
# Virtually indexed, physically tagged write-back data cache

This block sits between a core's load/store port and a word-wide memory port and holds 1 KB of data in 64 direct-mapped lines of four 32-bit words. A request is accepted with the virtual address, which alone selects the set. The translated physical address arrives one cycle later and is compared with the stored physical tag. A hit answers in that same cycle. A store hit writes the selected bytes and marks the line dirty, and sends nothing to memory.

On a miss the core is stalled. If the victim line is valid and dirty, its four words go to memory first. The new line is then fetched one word at a time, and the stalled request is replayed against the refilled line. A store miss therefore allocates: the line is fetched, and the store bytes are then merged into it. A separate invalidate pin drops one line without writing it back.

Two valid/ready flows cross the edge. The core side applies back-pressure through `req_ready`: a request moves only in a cycle where `req_valid` and `req_ready` are both high. The core must take a response whenever `rsp_valid` is high. On the memory side the cache holds `mem_req_valid` and every request field steady until `mem_req_ready` is seen. Read data comes back later as a single `mem_rsp_valid` pulse, and the next fetch is not issued until that pulse arrives.

Top module: `dcv_cache`

## Requirements
- R1: A request accepted in cycle N is answered in cycle N+1 when it hits: `rsp_valid` high, `core_stall` low, and for a load `rsp_rdata` holds the addressed word.
- R2: The set is virtual address bits [9:4] and the word is bits [3:2]. A hit needs a valid line whose stored tag equals physical address bits [31:10] presented on `xlat_paddr` in cycle N+1. Virtual bits [31:10] have no effect on the outcome.
- R3: A store hit writes byte lane i (data bits 8i+7..8i) only where `req_be[i]` is 1, marks the line dirty, and issues no memory request.
- R4: A miss on an invalid or clean line issues exactly four reads, for words 0,1,2,3 in that order, at address {physical tag, set, word, 2'b00}, and no writes.
- R5: A miss on a valid dirty line first issues four writes carrying the victim's words 0..3 at address {victim tag, set, word, 2'b00}, and only then issues the four reads.
- R6: A store miss fetches the line, then merges the store bytes under `req_be`, and leaves the line dirty.
- R7: From the miss cycle until the cycle that carries `rsp_valid`, `core_stall` stays high and `req_ready` stays low.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the next cycle keeps `mem_req_valid` high with the address, write flag and write data unchanged.
- R9: Reset clears every valid and dirty bit. After reset `req_ready` is 1, and `core_stall`, `rsp_valid` and `mem_req_valid` are 0. The first access therefore misses.
- R10: A pulse on `inv_valid` clears the valid and dirty bits of set `inv_index` from the next cycle. The data is discarded without a write-back, and the next access to that set refetches from memory. A refill that completes in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request offered |
| req_ready | output | 1 | Cache can take a request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| xlat_paddr | input | 32 | Physical address, valid the cycle after acceptance |
| rsp_valid | output | 1 | Request completes this cycle |
| rsp_rdata | output | 32 | Load data |
| core_stall | output | 1 | Miss in progress |
| inv_valid | input | 1 | Invalidate one set |
| inv_index | input | 6 | Set to invalidate |
| mem_req_valid | output | 1 | Memory word request offered |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = write word, 0 = read word |
| mem_req_addr | output | 32 | Word-aligned physical byte address |
| mem_req_wdata | output | 32 | Write-back data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
The bench builds the cache with its default parameters: 64 sets of four 32-bit words and 32-bit addresses. Physical tags are limited to eight values, so the physical space is an 8 KB array, and the random phase confines accesses to eight sets. Together with random virtual upper bits, random `mem_req_ready` gaps and read latencies of one to three cycles, this makes dirty evictions, store allocation, set conflicts and requests held under back-pressure frequent.

// File: rtl/dcv_pkg.sv
package dcv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,   // lookups and hits
    ST_EVICT,  // writing the dirty victim
    ST_FETCH,  // offering a word read
    ST_WAIT    // waiting for read data
  } fill_state_e;
endpackage

// File: rtl/dcv_tag_store.sv
module dcv_tag_store #(
  parameter int SETS  = 64,
  parameter int TAG_W = 22,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             dirty_en,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx
);
  logic [SETS-1:0]  valid_q;
  logic [SETS-1:0]  dirty_q;
  logic [TAG_W-1:0] tag_q [SETS];

  // later statements win: a completing refill overrides an invalidate
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (dirty_en) dirty_q[idx] <= 1'b1;
      if (inv_en) begin
        valid_q[inv_idx] <= 1'b0;
        dirty_q[inv_idx] <= 1'b0;
      end
      if (fill_en) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[idx] <= fill_tag;
  end

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_tag   = tag_q[idx];
endmodule

// File: rtl/dcv_data_store.sv
module dcv_data_store #(
  parameter int SETS       = 64,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  localparam int IDX_W     = $clog2(SETS),
  localparam int WSEL_W    = $clog2(LINE_WORDS),
  localparam int LANES     = DATA_W / 8,
  localparam int DEPTH     = SETS * LINE_WORDS
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WSEL_W-1:0] word,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [IDX_W+WSEL_W-1:0] addr;
  assign addr = {idx, word};

  // one storage array per byte lane
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [7:0] lane_q [DEPTH];
    always_ff @(posedge clk) begin
      if (we && be[b]) lane_q[addr] <= wdata[8*b +: 8];
    end
    assign rdata[8*b +: 8] = lane_q[addr];
  end
endmodule

// File: rtl/dcv_ctrl.sv
module dcv_ctrl
  import dcv_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 64,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  localparam int IDX_W     = $clog2(SETS),
  localparam int WSEL_W    = $clog2(LINE_WORDS),
  localparam int OFF_W     = WSEL_W + 2,
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
  localparam int LANES     = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic [ADDR_W-1:0] xlat_paddr,
  output logic              rsp_valid,
  output logic              core_stall,
  output logic [IDX_W-1:0]  line_idx,
  input  logic              look_valid,
  input  logic              look_dirty,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              fill_en,
  output logic [TAG_W-1:0]  fill_tag,
  output logic              dirty_en,
  output logic [WSEL_W-1:0] dat_word,
  output logic              dat_we,
  output logic [LANES-1:0]  dat_be,
  output logic [DATA_W-1:0] dat_wdata,
  input  logic [DATA_W-1:0] dat_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);
  fill_state_e       state_q;
  logic [WSEL_W-1:0] cnt_q;
  logic              s2_valid_q, s2_first_q, s2_write_q;
  logic [IDX_W-1:0]  s2_idx_q;
  logic [WSEL_W-1:0] s2_word_q;
  logic [DATA_W-1:0] s2_wdata_q;
  logic [LANES-1:0]  s2_be_q;
  logic [TAG_W-1:0]  held_tag_q;

  logic [TAG_W-1:0] cmp_tag;
  logic idle, hit, hit_now, miss_now, last_word, refill_word;
  logic unused_addr_bits;

  assign unused_addr_bits = ^{req_vaddr[ADDR_W-1:OFF_W+IDX_W], req_vaddr[1:0],
                              xlat_paddr[OFF_W+IDX_W-1:0]};

  // the translated tag is live only in the first lookup cycle; replays use the held copy
  assign cmp_tag   = s2_first_q ? xlat_paddr[ADDR_W-1 -: TAG_W] : held_tag_q;
  assign idle      = (state_q == ST_IDLE);
  assign hit       = s2_valid_q && look_valid && (look_tag == cmp_tag);
  assign hit_now   = idle && hit;
  assign miss_now  = idle && s2_valid_q && !hit;
  assign last_word = (cnt_q == WSEL_W'(LINE_WORDS - 1));
  assign refill_word = (state_q == ST_WAIT) && mem_rsp_valid;

  assign req_ready  = idle && (!s2_valid_q || hit);
  assign rsp_valid  = hit_now;
  assign core_stall = miss_now || !idle;

  assign line_idx = s2_idx_q;
  assign dirty_en = hit_now && s2_write_q;
  assign fill_en  = refill_word && last_word;
  assign fill_tag = held_tag_q;

  assign dat_word  = idle ? s2_word_q : cnt_q;
  assign dat_we    = dirty_en || refill_word;
  assign dat_be    = refill_word ? '1 : s2_be_q;
  assign dat_wdata = refill_word ? mem_rsp_rdata : s2_wdata_q;

  assign mem_req_valid = (state_q == ST_EVICT) || (state_q == ST_FETCH);
  assign mem_req_write = (state_q == ST_EVICT);
  assign mem_req_addr  = {(state_q == ST_EVICT) ? look_tag : held_tag_q,
                          s2_idx_q, cnt_q, 2'b00};
  assign mem_req_wdata = dat_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      s2_valid_q <= 1'b0;
      s2_first_q <= 1'b0;
      s2_write_q <= 1'b0;
      s2_idx_q   <= '0;
      s2_word_q  <= '0;
      s2_wdata_q <= '0;
      s2_be_q    <= '0;
      held_tag_q <= '0;
    end else begin
      s2_first_q <= 1'b0;
      if (s2_first_q) held_tag_q <= cmp_tag;
      if (req_valid && req_ready) begin
        s2_valid_q <= 1'b1;
        s2_first_q <= 1'b1;
        s2_write_q <= req_write;
        s2_idx_q   <= req_vaddr[OFF_W +: IDX_W];
        s2_word_q  <= req_vaddr[2 +: WSEL_W];
        s2_wdata_q <= req_wdata;
        s2_be_q    <= req_be;
      end else if (hit_now) begin
        s2_valid_q <= 1'b0;
      end
      unique case (state_q)
        ST_IDLE: if (miss_now) begin
          cnt_q   <= '0;
          state_q <= (look_valid && look_dirty) ? ST_EVICT : ST_FETCH;
        end
        ST_EVICT: if (mem_req_ready) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_word) state_q <= ST_FETCH;
        end
        ST_FETCH: if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          cnt_q   <= cnt_q + 1'b1;
          state_q <= last_word ? ST_IDLE : ST_FETCH;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcv_cache.sv
module dcv_cache #(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 64,
  parameter int LINE_WORDS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_vaddr,
  input  logic [31:0]             req_wdata,
  input  logic [3:0]              req_be,
  input  logic [ADDR_W-1:0]       xlat_paddr,
  output logic                    rsp_valid,
  output logic [31:0]             rsp_rdata,
  output logic                    core_stall,
  input  logic                    inv_valid,
  input  logic [$clog2(SETS)-1:0] inv_index,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic                    mem_req_write,
  output logic [ADDR_W-1:0]       mem_req_addr,
  output logic [31:0]             mem_req_wdata,
  input  logic                    mem_rsp_valid,
  input  logic [31:0]             mem_rsp_rdata
);
  localparam int DATA_W = 32;
  localparam int IDX_W  = $clog2(SETS);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - 2;

  logic [IDX_W-1:0]  line_idx;
  logic              look_valid, look_dirty, fill_en, dirty_en, dat_we;
  logic [TAG_W-1:0]  look_tag, fill_tag;
  logic [WSEL_W-1:0] dat_word;
  logic [3:0]        dat_be;
  logic [DATA_W-1:0] dat_wdata, dat_rdata;

  dcv_ctrl #(.ADDR_W(ADDR_W), .SETS(SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_ctrl (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_vaddr, .req_wdata, .req_be,
    .xlat_paddr, .rsp_valid, .core_stall, .line_idx, .look_valid, .look_dirty, .look_tag,
    .fill_en, .fill_tag, .dirty_en, .dat_word, .dat_we, .dat_be, .dat_wdata, .dat_rdata,
    .mem_req_valid, .mem_req_ready, .mem_req_write, .mem_req_addr, .mem_req_wdata,
    .mem_rsp_valid, .mem_rsp_rdata
  );

  dcv_tag_store #(.SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk, .rst_n, .idx(line_idx), .rd_valid(look_valid), .rd_dirty(look_dirty),
    .rd_tag(look_tag), .fill_en, .fill_tag, .dirty_en, .inv_en(inv_valid),
    .inv_idx(inv_index)
  );

  dcv_data_store #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
    .clk, .idx(line_idx), .word(dat_word), .we(dat_we), .be(dat_be),
    .wdata(dat_wdata), .rdata(dat_rdata)
  );

  assign rsp_rdata = dat_rdata;
endmodule

// File: rtl/dcv_checker.sv
module dcv_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              core_stall,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [31:0]       mem_req_wdata
);
  logic [7:0] wr_seen;

  // write handshakes since the current miss began
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_seen <= '0;
    else if (!core_stall) wr_seen <= '0;
    else if (mem_req_valid && mem_req_ready && mem_req_write) wr_seen <= wr_seen + 8'd1;
  end

  p_answer_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid || core_stall));

  p_stall_blocks_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |-> !req_ready);

  p_stall_ends_with_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_stall) |-> rsp_valid);

  p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  p_evict_whole_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && !mem_req_write) |->
      (wr_seen == 8'd0 || wr_seen == 8'(LINE_WORDS)));
endmodule

bind dcv_cache dcv_checker #(.ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .core_stall(core_stall), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata)
);

// File: tb/test_dcv_cache.sv
module test_dcv_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0, req_wdata = '0, xlat_paddr = '0;
  logic [3:0]  req_be = '0;
  logic        req_ready, rsp_valid, core_stall;
  logic [31:0] rsp_rdata;
  logic        inv_valid = 1'b0;
  logic [5:0]  inv_index = '0;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  dcv_cache i_dcv_cache (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] bmem [2048];
  logic [31:0] gmem [2048];
  bit          mv [64];
  bit          md [64];
  logic [21:0] mt [64];
  logic [31:0] mdat [64][4];
  int n_wr = 0, n_rd = 0, wr_base = 0, rd_base = 0, order_bad = 0, hold_bad = 0;
  logic [31:0] wr_log [8];
  logic [31:0] wr_dat [8];
  logic [31:0] rd_log [8];
  bit rd_pend = 0;
  int rd_wait = 0;
  logic [10:0] rd_addr = '0;
  bit prev_block = 0;
  logic [31:0] prev_addr = '0, prev_data = '0;
  logic prev_w = 1'b0;

  function automatic logic [31:0] init_word(input int i);
    return (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) cyc++;
  initial begin
    wait (cyc > 150000);
    checks++; errors++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    finish_run();
  end

  always @(negedge clk) mem_req_ready = ($urandom % 4) != 0;

  // memory model: one word per handshake, reads answered after 1..3 cycles
  always @(posedge clk) begin : mem_model
    int k;
    mem_rsp_valid <= 1'b0;
    if (rd_pend) begin
      if (rd_wait == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= bmem[rd_addr];
        rd_pend <= 0;
      end else rd_wait <= rd_wait - 1;
    end
    if (rst_n) begin
      if (prev_block && (!mem_req_valid || mem_req_addr !== prev_addr ||
          mem_req_write !== prev_w || mem_req_wdata !== prev_data)) hold_bad++;
      prev_block = mem_req_valid && !mem_req_ready;
      prev_addr = mem_req_addr; prev_w = mem_req_write; prev_data = mem_req_wdata;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          k = n_wr - wr_base;
          if (k < 8) begin wr_log[k] = mem_req_addr; wr_dat[k] = mem_req_wdata; end
          if (n_rd != rd_base) order_bad++;
          bmem[mem_req_addr[12:2]] = mem_req_wdata;
          n_wr++;
        end else begin
          k = n_rd - rd_base;
          if (k < 8) rd_log[k] = mem_req_addr;
          rd_pend <= 1;
          rd_addr <= mem_req_addr[12:2];
          rd_wait <= int'($urandom % 3);
          n_rd++;
        end
      end
    end
  end

  task automatic access(input bit wr, input logic [31:0] va, input logic [2:0] pt,
                        input logic [31:0] wd, input logic [3:0] be,
                        output logic [31:0] got, output int lat);
    logic [31:0] pa, exp_rd;
    logic [21:0] vtag;
    int idx, w, ob;
    bit hit_e, wb_e, stall_ok;
    pa = {19'd0, pt, va[9:0]};
    idx = int'(va[9:4]); w = int'(va[3:2]);
    hit_e = mv[idx] && mt[idx] == pa[31:10];
    wb_e = !hit_e && mv[idx] && md[idx];
    vtag = mt[idx];
    if (!hit_e) begin
      if (wb_e) for (int k = 0; k < 4; k++) gmem[{vtag[2:0], 6'(idx), 2'(k)}] = mdat[idx][k];
      for (int k = 0; k < 4; k++) mdat[idx][k] = gmem[{pt, 6'(idx), 2'(k)}];
      mv[idx] = 1; md[idx] = 0; mt[idx] = pa[31:10];
    end
    exp_rd = mdat[idx][w];
    if (wr) begin mdat[idx][w] = merge(exp_rd, wd, be); md[idx] = 1; end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_vaddr = va; req_wdata = wd; req_be = be;
    wr_base = n_wr; rd_base = n_rd; ob = order_bad;
    @(negedge clk);
    req_valid = 0; xlat_paddr = pa;
    #1;
    lat = 0; stall_ok = 1;
    while (!rsp_valid && lat < 3000) begin
      if (!core_stall || req_ready) stall_ok = 0;
      @(negedge clk);
      xlat_paddr = $urandom;
      #1;
      lat++;
    end
    got = rsp_rdata;
    check("R7 rsp_valid seen", 32'(rsp_valid), 1);
    check("R7 stall low with response", 32'(core_stall), 0);
    if (hit_e) begin
      check("R1 hit latency", lat, 0);
      check("R3 no memory traffic on hit", n_wr - wr_base + n_rd - rd_base, 0);
    end else begin
      check("R7 stall held through miss", 32'(stall_ok), 1);
      check("R4 reads per miss", n_rd - rd_base, 4);
      check("R5 writes per miss", n_wr - wr_base, wb_e ? 4 : 0);
      check("R5 writes before reads", order_bad - ob, 0);
      for (int k = 0; k < 4; k++) begin
        check("R4 fetch address order", rd_log[k], {19'd0, pt, va[9:4], 2'(k), 2'b00});
        if (wb_e) begin
          check("R5 victim address", wr_log[k], {19'd0, vtag[2:0], va[9:4], 2'(k), 2'b00});
          check("R5 victim data", wr_dat[k], gmem[{vtag[2:0], va[9:4], 2'(k)}]);
        end
      end
    end
    if (!wr) check(hit_e ? "R1 load data" : "R4 load data after refill", got, exp_rd);
  endtask

  task automatic invalidate(input logic [5:0] i);
    @(negedge clk);
    inv_valid = 1; inv_index = i;
    @(negedge clk);
    inv_valid = 0;
    mv[i] = 0; md[i] = 0;
  endtask

  initial begin
    logic [31:0] got;
    int lat, wsave, bad;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2048; i++) begin bmem[i] = init_word(i); gmem[i] = init_word(i); end
    for (int i = 0; i < 64; i++) begin mv[i] = 0; md[i] = 0; mt[i] = '0; end
    repeat (3) @(negedge clk);
    #1;
    check("R9 reset req_ready", 32'(req_ready), 1);
    check("R9 reset core_stall", 32'(core_stall), 0);
    check("R9 reset rsp_valid", 32'(rsp_valid), 0);
    check("R9 reset mem_req_valid", 32'(mem_req_valid), 0);
    @(negedge clk); rst_n = 1;

    // first access after reset must miss
    access(0, 32'h0000_0104, 3'd1, 0, 0, got, lat);
    check("R9 first access misses", 32'(lat > 0), 1);
    check("R9 first load data", got, init_word({3'd1, 6'h10, 2'd1}));
    // same set and physical tag, different virtual upper bits: hit
    access(0, 32'hFFFF_F108, 3'd1, 0, 0, got, lat);
    check("R2 upper virtual bits ignored", lat, 0);
    check("R2 hit data", got, init_word({3'd1, 6'h10, 2'd2}));
    // store hit with lanes 0 and 2
    access(1, 32'h0000_0108, 3'd1, 32'hAABBCCDD, 4'b0101, got, lat);
    check("R3 store hit latency", lat, 0);
    access(0, 32'h0000_0108, 3'd1, 0, 0, got, lat);
    check("R3 byte lane merge", got, merge(init_word({3'd1, 6'h10, 2'd2}), 32'hAABBCCDD, 4'b0101));
    // same set, other physical tag: dirty eviction
    access(0, 32'h0000_0100, 3'd2, 0, 0, got, lat);
    check("R2 tag mismatch misses", 32'(lat > 0), 1);
    check("R5 victim reached memory", bmem[{3'd1, 6'h10, 2'd2}],
          merge(init_word({3'd1, 6'h10, 2'd2}), 32'hAABBCCDD, 4'b0101));
    // store miss allocates and merges
    access(1, 32'h0000_0204, 3'd3, 32'h11223344, 4'b1100, got, lat);
    check("R6 store miss refills", 32'(lat > 0), 1);
    access(0, 32'h0000_0204, 3'd3, 0, 0, got, lat);
    check("R6 allocated line hits", lat, 0);
    check("R6 merged store data", got, merge(init_word({3'd3, 6'h20, 2'd1}), 32'h11223344, 4'b1100));
    // invalidate the dirty line: data dropped, no write-back
    wsave = n_wr;
    invalidate(6'h20);
    access(0, 32'h0000_0204, 3'd3, 0, 0, got, lat);
    check("R10 refetch after invalidate", 32'(lat > 0), 1);
    check("R10 no write-back", n_wr - wsave, 0);
    check("R10 store discarded", got, init_word({3'd3, 6'h20, 2'd1}));

    // random phase over eight sets and four physical tags
    for (int i = 0; i < 700; i++) begin
      logic [31:0] va;
      va = ($urandom & 32'hFFFF_FC0C) | ({26'd0, 6'($urandom % 8)} << 4);
      if ($urandom % 16 == 0) invalidate(6'($urandom % 8));
      else access(bit'($urandom % 2), va, 3'($urandom % 4), $urandom, 4'($urandom),
                  got, lat);
    end

    bad = 0;
    for (int i = 0; i < 2048; i++) if (bmem[i] !== gmem[i]) bad++;
    check("R5 memory image after evictions", bad, 0);
    check("R8 request held under back-pressure", hold_bad, 0);
    finish_run();
  end
endmodule